// File: doc/BRIEF.md
# Framed Stream Test Sequence Stamper

This block sits inline on a framed streaming path (valid, start-of-packet, end-of-packet, data, with ready and xon flowing back). When enabled, it overwrites the data field of every beat that passes with a test sequence word. Valid, sop and eop are not altered, so the packet boundaries of the incoming traffic stay the same while the payload becomes a known pattern. A receiver can check that pattern. When disabled, the stream passes through untouched.

Two generators produce the sequence: a wrapping binary counter and a maximal-length Fibonacci LFSR. A mode input selects which one is written into the data field. Each accepted input beat is the request for one sequence word. Idle cycles and stalled cycles therefore never consume a word. The sequence word is narrower than, or as wide as, the data field, and it is zero-extended into it. The output goes through one register stage. That stage honours downstream ready, so the block also acts as a one-deep pipeline register.

Top module: `frame_seq_stamper`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0. After reset with no input beats, out_valid_o stays 0 and in_ready_o is 1.
- R2: In the cycle after a clock edge at which in_ready_o is 1, out_valid_o, out_sop_o and out_eop_o equal the in_valid_i, in_sop_i and in_eop_i values sampled at that edge. This gives one cycle of latency with framing unchanged.
- R3: When en_i is 0 at the edge where a beat is accepted, out_data_o carries that beat's in_data_i unmodified.
- R4: With en_i = 1 and mode_i = 0 (counter), the first accepted beat after enabling carries 0. Each later accepted beat carries the previous value plus 1, modulo 2^SEQ_W.
- R5: With en_i = 1 and mode_i = 1 (pseudo-random), the first accepted beat after enabling carries the SEED parameter. Each later word is the previous one shifted left by one, with the XOR of the tap bits entering at bit 0. For SEQ_W = 8 the tap bits are 7, 5, 4 and 3.
- R6: When enabled, bits DATA_W-1 down to SEQ_W of out_data_o are 0 on every valid output beat.
- R7: Only accepted beats (in_valid_i and in_ready_o both 1 at a clock edge) advance the sequence. Cycles without valid, or with in_ready_o low, leave it unchanged.
- R8: in_ready_o is 1 exactly when out_ready_i is 1 or out_valid_o is 0. While out_valid_o is 1 and out_ready_i is 0, all outputs hold their values.
- R9: in_xon_o follows out_xon_i in the same cycle.
- R10: Both generators advance together on every accepted enabled beat, whatever the mode. Changing mode_i mid-stream yields the other generator's word for the same beat count.
- R11: A cycle with en_i = 0 returns the counter to 0 and the LFSR to SEED. Re-enabling restarts both sequences from their first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 = overwrite data with the sequence, 0 = pass data through |
| mode_i | input | 1 | 0 = counter, 1 = pseudo-random |
| in_valid_i | input | 1 | Input beat valid |
| in_sop_i | input | 1 | Input start of packet |
| in_eop_i | input | 1 | Input end of packet |
| in_data_i | input | DATA_W | Input data |
| in_ready_o | output | 1 | Upstream may present a beat |
| in_xon_o | output | 1 | Block-level flow control to upstream |
| out_valid_o | output | 1 | Output beat valid |
| out_sop_o | output | 1 | Output start of packet |
| out_eop_o | output | 1 | Output end of packet |
| out_data_o | output | DATA_W | Output data |
| out_ready_i | input | 1 | Downstream accepts the output beat |
| out_xon_i | input | 1 | Block-level flow control from downstream |

## Verification
The bench builds the block with DATA_W = 20, SEQ_W = 8 and SEED = 8'h5A. An 8-bit sequence makes the counter wrap and the whole 255-word LFSR cycle reachable within a few hundred beats. The twelve spare upper data bits make the zero-extension visible. Random valid gaps and random downstream stalls check that only accepted beats consume sequence words, and mid-stream mode switches and enable toggles check the lockstep and restart behaviour.

// File: rtl/seq_stamp_pkg.sv
package seq_stamp_pkg;

  typedef enum logic {
    SEQ_COUNT = 1'b0,
    SEQ_PRBS  = 1'b1
  } seq_mode_e;

  // maximal-length Fibonacci feedback masks, bit k set = state bit k is a tap
  function automatic logic [31:0] lfsr_tap_mask(input int unsigned w);
    case (w)
      3:  return 32'h0000_0006;
      4:  return 32'h0000_000C;
      5:  return 32'h0000_0014;
      6:  return 32'h0000_0030;
      7:  return 32'h0000_0060;
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0829;
      13: return 32'h0000_100D;
      14: return 32'h0000_2015;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      17: return 32'h0001_2000;
      18: return 32'h0002_0400;
      19: return 32'h0004_0023;
      20: return 32'h0009_0000;
      21: return 32'h0014_0000;
      22: return 32'h0030_0000;
      23: return 32'h0042_0000;
      24: return 32'h00E1_0000;
      25: return 32'h0120_0000;
      26: return 32'h0200_0023;
      27: return 32'h0400_0013;
      28: return 32'h0900_0000;
      29: return 32'h1400_0000;
      30: return 32'h2000_0029;
      31: return 32'h4800_0000;
      32: return 32'h8020_0003;
      default: return 32'h0000_0006;
    endcase
  endfunction

endpackage

// File: rtl/seq_count_gen.sv
module seq_count_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end

  assign word_o = cnt_q;

endmodule

// File: rtl/seq_prbs_gen.sv
module seq_prbs_gen
  import seq_stamp_pkg::*;
#(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  SEED = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] word_o
);

  localparam logic [31:0]  TAPS_FULL = lfsr_tap_mask(W);
  localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];

  logic [W-1:0] lfsr_q;
  logic         fb;

  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (clr_i)  lfsr_q <= SEED;
    else if (step_i) lfsr_q <= {lfsr_q[W-2:0], fb};
  end

  assign word_o = lfsr_q;

endmodule

// File: rtl/seq_out_stage.sv
module seq_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         valid_i,
  input  logic         sop_i,
  input  logic         eop_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic         sop_o,
  output logic         eop_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= valid_i;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      data_o  <= data_i;
    end
  end

endmodule

// File: rtl/frame_seq_stamper.sv
module frame_seq_stamper
  import seq_stamp_pkg::*;
#(
  parameter int unsigned       DATA_W = 32,
  parameter int unsigned       SEQ_W  = 16,
  parameter logic [SEQ_W-1:0]  SEED   = SEQ_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              in_xon_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  input  logic              out_xon_i
);

  seq_mode_e         mode;
  logic              stage_rdy;
  logic              accept;
  logic              step;
  logic [SEQ_W-1:0]  cnt_word;
  logic [SEQ_W-1:0]  prbs_word;
  logic [SEQ_W-1:0]  seq_word;
  logic [DATA_W-1:0] stamped;

  assign mode      = seq_mode_e'(mode_i);
  assign stage_rdy = out_ready_i | ~out_valid_o;
  assign accept    = in_valid_i & stage_rdy;
  assign step      = accept & en_i;

  assign in_ready_o = stage_rdy;
  assign in_xon_o   = out_xon_i;

  // both generators step in lockstep so a mode change keeps beat alignment
  seq_count_gen #(.W(SEQ_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .step_i (step),
    .word_o (cnt_word)
  );

  seq_prbs_gen #(.W(SEQ_W), .SEED(SEED)) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .step_i (step),
    .word_o (prbs_word)
  );

  assign seq_word = (mode == SEQ_PRBS) ? prbs_word : cnt_word;
  assign stamped  = en_i ? DATA_W'(seq_word) : in_data_i;

  seq_out_stage #(.W(DATA_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (stage_rdy),
    .valid_i (in_valid_i),
    .sop_i   (in_sop_i),
    .eop_i   (in_eop_i),
    .data_i  (stamped),
    .valid_o (out_valid_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o),
    .data_o  (out_data_o)
  );

endmodule

// File: rtl/frame_seq_stamper_chk.sv
module frame_seq_stamper_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEQ_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              in_valid_i,
  input logic              in_sop_i,
  input logic              in_eop_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i
);

  initial begin
    assert_width_fit_R6: assert (SEQ_W <= DATA_W && SEQ_W >= 3);
  end

  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (!out_valid_o);
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> (out_valid_o == $past(in_valid_i)));

  assert_sop_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> (out_sop_o == $past(in_sop_i)));

  assert_eop_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> (out_eop_o == $past(in_eop_i)));

  assert_pass_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && in_valid_i && !en_i) |=> (out_data_o == $past(in_data_i)));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
                                       && $stable(out_sop_o) && $stable(out_eop_o)));

  assert_stall_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  generate
    if (DATA_W > SEQ_W) begin : g_upper
      assert_zero_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_ready_o && in_valid_i && en_i) |=> (out_data_o[DATA_W-1:SEQ_W] == '0));
    end
  endgenerate

endmodule

bind frame_seq_stamper frame_seq_stamper_chk #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .in_valid_i  (in_valid_i),
  .in_sop_i    (in_sop_i),
  .in_eop_i    (in_eop_i),
  .in_data_i   (in_data_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i)
);

// File: tb/frame_seq_stamper_test.sv
module frame_seq_stamper_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          DW = 20;
  localparam int          SW = 8;
  localparam logic [7:0]  SEED_V = 8'h5A;
  localparam int          PKT_LEN = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          mode_i = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_sop_i = 1'b0;
  logic          in_eop_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_ready_o;
  logic          in_xon_o;
  logic          out_valid_o;
  logic          out_sop_o;
  logic          out_eop_o;
  logic [DW-1:0] out_data_o;
  logic          out_ready_i = 1'b1;
  logic          out_xon_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int beat_idx = 0;
  string phase_tag = "R1";

  // reference model state
  logic          m_valid = 1'b0;
  logic          m_sop = 1'b0;
  logic          m_eop = 1'b0;
  logic [DW-1:0] m_data = '0;
  int            m_cnt = 0;
  logic [7:0]    m_lfsr = SEED_V;

  frame_seq_stamper #(.DATA_W(DW), .SEQ_W(SW), .SEED(SEED_V)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .in_valid_i  (in_valid_i),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .in_xon_o    (in_xon_o),
    .out_valid_o (out_valid_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .out_xon_i   (out_xon_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    logic rdy;
    logic fb;
    cycles++;
    if (!rst_ni) begin
      m_valid = 1'b0;
      m_cnt   = 0;
      m_lfsr  = SEED_V;
    end else begin
      rdy = out_ready_i || !m_valid;
      if (rdy) begin
        m_valid = in_valid_i;
        m_sop   = in_sop_i;
        m_eop   = in_eop_i;
        if (en_i) m_data = mode_i ? DW'(m_lfsr) : DW'(m_cnt);
        else      m_data = in_data_i;
      end
      if (!en_i) begin
        m_cnt  = 0;
        m_lfsr = SEED_V;
      end else if (rdy && in_valid_i) begin
        m_cnt  = (m_cnt + 1) % 256;
        fb     = m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3];
        m_lfsr = {m_lfsr[6:0], fb};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", req, phase_tag, $time, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R2 valid", 32'(out_valid_o), 32'(m_valid));
    if (m_valid) begin
      chk("R2 sop", 32'(out_sop_o), 32'(m_sop));
      chk("R2 eop", 32'(out_eop_o), 32'(m_eop));
      chk("R3/R4/R5/R7 data", 32'(out_data_o), 32'(m_data));
    end
  endtask

  // one cycle: compare registered outputs, drive new inputs, compare combinational outputs
  task automatic step(input int valid_pct, input int ready_pct);
    @(negedge clk_i);
    check_outputs();
    out_ready_i = ($urandom_range(99) < ready_pct);
    in_valid_i  = ($urandom_range(99) < valid_pct);
    in_sop_i    = in_valid_i && (beat_idx == 0);
    in_eop_i    = in_valid_i && (beat_idx == PKT_LEN-1);
    in_data_i   = DW'($urandom);
    #1;
    chk("R8 ready", 32'(in_ready_o), 32'(out_ready_i || !m_valid));
    chk("R9 xon", 32'(in_xon_o), 32'(out_xon_i));
    if (in_valid_i && in_ready_o) beat_idx = (beat_idx + 1) % PKT_LEN;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    #(3*CLK_PERIOD);
    chk("R1 valid in reset", 32'(out_valid_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1 idle valid", 32'(out_valid_o), 32'd0);
      chk("R1 idle ready", 32'(in_ready_o), 32'd1);
    end

    // R3: disabled passthrough, full and gapped traffic
    phase_tag = "R3";
    repeat (60) step(100, 100);
    repeat (60) step(50, 100);

    // R4 / R6 / R7: counter with gaps, past the wrap
    phase_tag = "R4";
    @(negedge clk_i);
    en_i = 1'b1;
    mode_i = 1'b0;
    repeat (700) step(60, 100);
    @(negedge clk_i);
    chk("R6 upper bits zero", 32'(out_data_o >> SW), 32'd0);

    // R8: downstream stalls
    phase_tag = "R8";
    repeat (400) step(80, 40);

    // R9: xon passthrough
    phase_tag = "R9";
    repeat (20) begin
      @(negedge clk_i);
      out_xon_i = $urandom_range(1);
      #1;
      chk("R9 xon follow", 32'(in_xon_o), 32'(out_xon_i));
    end
    out_xon_i = 1'b1;

    // R11 + R5: restart, then full LFSR period with stalls and gaps
    phase_tag = "R11";
    @(negedge clk_i);
    in_valid_i = 1'b0;
    en_i = 1'b0;
    @(negedge clk_i);
    check_outputs();
    en_i = 1'b1;
    mode_i = 1'b1;
    phase_tag = "R5";
    repeat (900) step(70, 70);

    // R10: mode flips mid-stream
    phase_tag = "R10";
    repeat (40) begin
      @(negedge clk_i);
      mode_i = $urandom_range(1);
      repeat (8) step(75, 85);
    end

    // R11: enable toggles with traffic in flight
    phase_tag = "R11";
    repeat (20) begin
      @(negedge clk_i);
      en_i = ~en_i;
      repeat (12) step(80, 80);
    end

    // R6: enabled beat upper bits
    phase_tag = "R6";
    @(negedge clk_i);
    en_i = 1'b1;
    repeat (50) begin
      step(100, 100);
      if (out_valid_o) chk("R6 upper bits zero", 32'(out_data_o >> SW), 32'd0);
    end

    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (3) step(0, 100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule